// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Alarm

This block is a memory-mapped real-time clock. It keeps the time of day (hours, minutes, seconds) and the date (day of month, month, two-digit year standing for 2000 to 2099) as packed BCD words. A binary weekday counter runs beside them. Each one-second strobe on `tick` advances all of these values. A matching alarm word pair is compared against the running time and date.

The clock does nothing until software writes a fixed 32-bit unlock key. Until then, ticks and writes to every other register are dropped. After the unlock, software sets the time and the alarm and enables the interrupt sources. It services `irq` by reading the status register and writing ones to the flags it has handled.

Registers are reached through a plain synchronous write port and a combinational read port that share one byte address. The block has no other handshake.

Top module: `rtc_bcd_cal`

## Requirements
- R1: After reset the block reads: offset 0x00 = 0 (inactive), time (0x0C) = 0x000000, calendar (0x10) = 0x000101, weekday (0x18) = 6, alarm words = 0, enable (0x28) = 0, status (0x2C) = 0. `irq` is low.
- R2: Writing 0xA5EB1357 to offset 0x00 sets the active bit (bit 0 of offset 0x00). Any other value leaves it clear. Once set, the bit stays set until reset.
- R3: While inactive, ticks and writes to offsets other than 0x00 have no effect on any register.
- R4: On a counted tick, seconds in time bits [7:0] step 59→00 and carry to minutes in [15:8]. Minutes step 59→00 and carry to hours in [23:16]. Hours step 23→00 and carry to the day. Every BCD digit stays within 0–9.
- R5: The day (calendar bits [7:0]) rolls to 01 after day 31, 30, or 28/29, according to the month in bits [15:8]. The roll advances the month, and the weekday counts 6→0.
- R6: The year in calendar bits [23:16] is a leap year when it is divisible by 4. In a leap year, February runs to day 29. Bit 0 of offset 0x24 reads 1 for a leap year and 0 otherwise.
- R7: Month 12 rolls to 01 and carries into the year, and year 99 wraps to 00.
- R8: Alarm flag (status bit 0) is set on the tick after which the time and calendar equal the alarm time (0x1C) and alarm calendar (0x20) words.
- R9: Update flag (status bit 1) is set on every counted tick.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A flag set in the same cycle as its clear survives.
- R11: `irq` is high exactly when some status bit and its enable bit (0x28 bit 0 for alarm, bit 1 for update) are both set.
- R12: A write to the time word in the same cycle as a tick loads the written value. The tick is lost.
- R13: Offset 0x14 always reads 1 in bit 0 (24-hour format). Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe, once per second |
| wrEn | input | 1 | Register write strobe |
| addr | input | 6 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt: OR of status AND enable |

## Verification
The bench aims at the carry chain's edges. Odd digits such as 09 must carry to 10, and the 23:59:59 on 31 December 2099 rollover must wrap every field at once. A counter that carried in binary would show 0x0A. A wrong month table would show day 31 in April.

February is tested in both a leap year and a common year. A wrong divisibility rule skips or repeats 29 February.

The tests also cover cases that are easy to get wrong:
- the alarm must match on the new time, not the old one, or it fires one second late;
- a status clear that coincides with a fresh update event must keep the flag;
- a time write that coincides with a tick must keep the written value;
- a locked clock must not count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BCD_W  = 8;
  localparam int WORD_W = 3 * BCD_W;

  localparam logic [7:0] OFF_UNLOCK  = 8'h00;
  localparam logic [7:0] OFF_TIME    = 8'h0C;
  localparam logic [7:0] OFF_CAL     = 8'h10;
  localparam logic [7:0] OFF_FORMAT  = 8'h14;
  localparam logic [7:0] OFF_WDAY    = 8'h18;
  localparam logic [7:0] OFF_ALMTIME = 8'h1C;
  localparam logic [7:0] OFF_ALMCAL  = 8'h20;
  localparam logic [7:0] OFF_LEAP    = 8'h24;
  localparam logic [7:0] OFF_IEN     = 8'h28;
  localparam logic [7:0] OFF_STATUS  = 8'h2C;

  typedef struct packed {
    logic advance;
    logic wrTime;
    logic wrCal;
    logic wrWday;
    logic wrAlmTime;
    logic wrAlmCal;
  } rtcStrobe_t;

  function automatic logic [BCD_W-1:0] bcdInc(input logic [BCD_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic isLeap(input logic [BCD_W-1:0] yr);
    if (yr[4] == 1'b0) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic logic [BCD_W-1:0] lastDay(input logic [BCD_W-1:0] mon, input logic leap);
    case (mon)
      8'h02: return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int WDAY_W     = 3,
  parameter int WDAY_MAX   = 6,
  parameter int WDAY_RESET = 6,
  parameter logic [WORD_W-1:0] CAL_RESET = 24'h000101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rtcStrobe_t        strobe,
  input  logic [WORD_W-1:0] wrWord,
  output logic [WORD_W-1:0] timeWord,
  output logic [WORD_W-1:0] calWord,
  output logic [WDAY_W-1:0] wdayOut,
  output logic [WORD_W-1:0] almTimeWord,
  output logic [WORD_W-1:0] almCalWord,
  output logic              leapYear,
  output logic              almHit
);
  logic [BCD_W-1:0] secQ, minQ, hourQ, dayQ, monQ, yearQ;
  logic [BCD_W-1:0] secN, minN, hourN, dayN, monN, yearN;
  logic [WDAY_W-1:0] wdayQ, wdayN;
  logic [WORD_W-1:0] almTimeQ, almCalQ;
  logic secWrap, minWrap, hourWrap, dayWrap, monWrap;

  assign leapYear = isLeap(yearQ);

  always_comb begin
    secWrap  = secQ >= 8'h59;
    minWrap  = secWrap && (minQ >= 8'h59);
    hourWrap = minWrap && (hourQ >= 8'h23);
    dayWrap  = hourWrap && (dayQ >= lastDay(monQ, leapYear));
    monWrap  = dayWrap && (monQ >= 8'h12);

    secN  = secWrap ? 8'h00 : bcdInc(secQ);
    minN  = !secWrap ? minQ : (minWrap ? 8'h00 : bcdInc(minQ));
    hourN = !minWrap ? hourQ : (hourWrap ? 8'h00 : bcdInc(hourQ));
    dayN  = !hourWrap ? dayQ : (dayWrap ? 8'h01 : bcdInc(dayQ));
    monN  = !dayWrap ? monQ : (monWrap ? 8'h01 : bcdInc(monQ));
    yearN = !monWrap ? yearQ : ((yearQ >= 8'h99) ? 8'h00 : bcdInc(yearQ));
    if (!hourWrap) wdayN = wdayQ;
    else if (wdayQ >= WDAY_W'(WDAY_MAX)) wdayN = '0;
    else wdayN = wdayQ + 1'b1;
  end

  assign almHit = strobe.advance && !strobe.wrTime && !strobe.wrCal &&
                  ({hourN, minN, secN} == almTimeQ) && ({yearN, monN, dayN} == almCalQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {hourQ, minQ, secQ} <= '0;
      {yearQ, monQ, dayQ} <= CAL_RESET;
      wdayQ    <= WDAY_W'(WDAY_RESET);
      almTimeQ <= '0;
      almCalQ  <= '0;
    end else begin
      if (strobe.wrTime) {hourQ, minQ, secQ} <= wrWord;
      else if (strobe.advance) {hourQ, minQ, secQ} <= {hourN, minN, secN};

      if (strobe.wrCal) {yearQ, monQ, dayQ} <= wrWord;
      else if (strobe.advance && !strobe.wrTime) {yearQ, monQ, dayQ} <= {yearN, monN, dayN};

      if (strobe.wrWday) wdayQ <= wrWord[WDAY_W-1:0];
      else if (strobe.advance && !strobe.wrTime) wdayQ <= wdayN;

      if (strobe.wrAlmTime) almTimeQ <= wrWord;
      if (strobe.wrAlmCal)  almCalQ  <= wrWord;
    end
  end

  assign timeWord    = {hourQ, minQ, secQ};
  assign calWord     = {yearQ, monQ, dayQ};
  assign wdayOut     = wdayQ;
  assign almTimeWord = almTimeQ;
  assign almCalWord  = almCalQ;

  assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.advance && !strobe.wrTime && secQ == 8'h59) |=> (secQ == 8'h00));

  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.advance && !strobe.wrTime) |=> $stable(timeWord));

  assert_year_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.advance && !strobe.wrTime && !strobe.wrCal &&
     timeWord == 24'h235959 && calWord == 24'h991231) |=> (calWord == 24'h000101));

  assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrTime) |=> (timeWord == $past(wrWord)));
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int WDAY_W = 3,
  parameter int IRQ_N  = 2,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'hA5EB1357
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [WORD_W-1:0] timeWord,
  input  logic [WORD_W-1:0] calWord,
  input  logic [WDAY_W-1:0] wdayIn,
  input  logic [WORD_W-1:0] almTimeWord,
  input  logic [WORD_W-1:0] almCalWord,
  input  logic              leapYear,
  input  logic              almHit,
  output rtcStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  logic activeQ;
  logic [IRQ_N-1:0] ienQ, statusQ, statusSet, statusClr;
  logic wrIen, wrStatus;

  function automatic logic hitAddr(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == off[ADDR_W-1:0];
  endfunction

  always_comb begin
    strobe.advance   = tick && activeQ;
    strobe.wrTime    = wrEn && activeQ && hitAddr(addr, OFF_TIME);
    strobe.wrCal     = wrEn && activeQ && hitAddr(addr, OFF_CAL);
    strobe.wrWday    = wrEn && activeQ && hitAddr(addr, OFF_WDAY);
    strobe.wrAlmTime = wrEn && activeQ && hitAddr(addr, OFF_ALMTIME);
    strobe.wrAlmCal  = wrEn && activeQ && hitAddr(addr, OFF_ALMCAL);
    wrIen            = wrEn && activeQ && hitAddr(addr, OFF_IEN);
    wrStatus         = wrEn && activeQ && hitAddr(addr, OFF_STATUS);
  end

  assign statusSet = {strobe.advance, almHit};
  assign statusClr = wrStatus ? wrData[IRQ_N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeQ <= 1'b0;
      ienQ    <= '0;
    end else begin
      if (wrEn && hitAddr(addr, OFF_UNLOCK) && wrData == UNLOCK_KEY) activeQ <= 1'b1;
      if (wrIen) ienQ <= wrData[IRQ_N-1:0];
    end
  end

  for (genvar i = 0; i < IRQ_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) statusQ[i] <= 1'b0;
      else statusQ[i] <= statusSet[i] | (statusQ[i] & ~statusClr[i]);
    end
  end

  assign irq = |(statusQ & ienQ);

  always_comb begin
    rdData = '0;
    case (addr)
      OFF_UNLOCK[ADDR_W-1:0]:  rdData[0] = activeQ;
      OFF_TIME[ADDR_W-1:0]:    rdData[WORD_W-1:0] = timeWord;
      OFF_CAL[ADDR_W-1:0]:     rdData[WORD_W-1:0] = calWord;
      OFF_FORMAT[ADDR_W-1:0]:  rdData[0] = 1'b1;
      OFF_WDAY[ADDR_W-1:0]:    rdData[WDAY_W-1:0] = wdayIn;
      OFF_ALMTIME[ADDR_W-1:0]: rdData[WORD_W-1:0] = almTimeWord;
      OFF_ALMCAL[ADDR_W-1:0]:  rdData[WORD_W-1:0] = almCalWord;
      OFF_LEAP[ADDR_W-1:0]:    rdData[0] = leapYear;
      OFF_IEN[ADDR_W-1:0]:     rdData[IRQ_N-1:0] = ienQ;
      OFF_STATUS[ADDR_W-1:0]:  rdData[IRQ_N-1:0] = statusQ;
      default:                 rdData = '0;
    endcase
  end

  assert_active_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    activeQ |=> activeQ);

  assert_locked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !activeQ |-> (ienQ == '0 && statusQ == '0));

  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ienQ == '0) |-> !irq);

  assert_alarm_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (statusQ[0] && !statusClr[0]) |=> statusQ[0]);

  assert_update_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance |=> statusQ[1]);
endmodule

// File: rtl/rtc_bcd_cal.sv
module rtc_bcd_cal
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'hA5EB1357
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam int WDAY_W = 3;
  localparam int IRQ_N  = 2;

  rtcStrobe_t strobe;
  logic [WORD_W-1:0] timeWord, calWord, almTimeWord, almCalWord;
  logic [WDAY_W-1:0] wday;
  logic leapYear, almHit;

  rtc_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WDAY_W(WDAY_W), .IRQ_N(IRQ_N), .UNLOCK_KEY(UNLOCK_KEY)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .timeWord(timeWord), .calWord(calWord), .wdayIn(wday), .almTimeWord(almTimeWord),
    .almCalWord(almCalWord), .leapYear(leapYear), .almHit(almHit),
    .strobe(strobe), .rdData(rdData), .irq(irq)
  );

  rtc_datapath #(.WDAY_W(WDAY_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrWord(wrData[WORD_W-1:0]),
    .timeWord(timeWord), .calWord(calWord), .wdayOut(wday), .almTimeWord(almTimeWord),
    .almCalWord(almCalWord), .leapYear(leapYear), .almHit(almHit)
  );
endmodule

// File: tb/rtc_bcd_cal_tb.sv
module rtc_bcd_cal_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wrEn = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irq;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  localparam logic [31:0] KEY = 32'hA5EB1357;

  always #2 clk = ~clk;

  rtc_bcd_cal u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wrEn(wrEn), .addr(addr),
                     .wrData(wrData), .rdData(rdData), .irq(irq));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic setClock(input logic [31:0] t, input logic [31:0] c, input logic [31:0] w);
    wr(6'h10, c); wr(6'h0C, t); wr(6'h18, w);
  endtask

  task automatic testReset();
    expectReg("R1 active", 6'h00, 0);
    expectReg("R1 time", 6'h0C, 32'h000000);
    expectReg("R1 cal", 6'h10, 32'h000101);
    expectReg("R1 wday", 6'h18, 6);
    expectReg("R1 almtime", 6'h1C, 0);
    expectReg("R1 ien", 6'h28, 0);
    expectReg("R1 status", 6'h2C, 0);
    check("R1 irq", {31'b0, irq}, 0);
    expectReg("R13 format", 6'h14, 1);
    expectReg("R6 leap 2000", 6'h24, 1);
  endtask

  task automatic testLocked();
    wr(6'h0C, 32'h123456);
    pulse();
    expectReg("R3 time locked", 6'h0C, 0);
    wr(6'h28, 3);
    expectReg("R3 ien locked", 6'h28, 0);
    expectReg("R3 status locked", 6'h2C, 0);
    wr(6'h00, 32'hA5EB1356);
    expectReg("R2 wrong key", 6'h00, 0);
    wr(6'h00, KEY);
    expectReg("R2 unlocked", 6'h00, 1);
    wr(6'h00, 0);
    expectReg("R2 sticky", 6'h00, 1);
  endtask

  task automatic testTimeCarry();
    setClock(32'h000009, 32'h250615, 2);
    pulse();
    expectReg("R4 digit carry", 6'h0C, 32'h000010);
    wr(6'h0C, 32'h005959);
    pulse();
    expectReg("R4 hour carry", 6'h0C, 32'h010000);
    wr(6'h0C, 32'h235959);
    pulse();
    expectReg("R4 day carry time", 6'h0C, 0);
    expectReg("R4 day carry cal", 6'h10, 32'h250616);
    expectReg("R5 wday step", 6'h18, 3);
  endtask

  task automatic testMonths();
    setClock(32'h235959, 32'h240430, 6);
    pulse();
    expectReg("R5 april end", 6'h10, 32'h240501);
    expectReg("R5 wday wrap", 6'h18, 0);
    setClock(32'h235959, 32'h240228, 0);
    expectReg("R6 leap 2024", 6'h24, 1);
    pulse();
    expectReg("R6 feb 29", 6'h10, 32'h240229);
    wr(6'h0C, 32'h235959);
    pulse();
    expectReg("R6 after feb 29", 6'h10, 32'h240301);
    setClock(32'h235959, 32'h230228, 0);
    expectReg("R6 leap 2023", 6'h24, 0);
    pulse();
    expectReg("R6 common feb", 6'h10, 32'h230301);
    setClock(32'h235959, 32'h991231, 5);
    pulse();
    expectReg("R7 year wrap cal", 6'h10, 32'h000101);
    expectReg("R7 year wrap time", 6'h0C, 0);
  endtask

  task automatic testAlarm();
    wr(6'h28, 0);
    wr(6'h20, 32'h250615);
    wr(6'h1C, 32'h100005);
    setClock(32'h100003, 32'h250615, 1);
    wr(6'h2C, 3);
    expectReg("R10 cleared", 6'h2C, 0);
    pulse();
    expectReg("R8 no early alarm", 6'h2C, 2);
    expectReg("R9 update flag", 6'h2C, 2);
    check("R11 irq disabled", {31'b0, irq}, 0);
    pulse();
    expectReg("R8 alarm hit", 6'h2C, 3);
    wr(6'h28, 1);
    check("R11 irq alarm", {31'b0, irq}, 1);
    wr(6'h2C, 1);
    expectReg("R10 w1c alarm", 6'h2C, 2);
    check("R11 irq gated", {31'b0, irq}, 0);
    wr(6'h28, 2);
    check("R11 irq update", {31'b0, irq}, 1);
    wr(6'h2C, 0);
    expectReg("R10 write zero", 6'h2C, 2);
    @(negedge clk); wrEn = 1'b1; addr = 6'h2C; wrData = 2; tick = 1'b1;
    @(negedge clk); wrEn = 1'b0; tick = 1'b0;
    expectReg("R10 set wins", 6'h2C, 2);
    wr(6'h2C, 2);
    check("R11 irq low", {31'b0, irq}, 0);
  endtask

  task automatic testPrecedence();
    @(negedge clk); wrEn = 1'b1; addr = 6'h0C; wrData = 32'h081530; tick = 1'b1;
    @(negedge clk); wrEn = 1'b0; tick = 1'b0;
    expectReg("R12 write wins", 6'h0C, 32'h081530);
    wr(6'h14, 0);
    expectReg("R13 format fixed", 6'h14, 1);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testLocked();
    testTimeCarry();
    testMonths();
    testAlarm();
    testPrecedence();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule